// File: doc/BRIEF.md
# SDRAM Command Decoder and Protocol Checker

This block watches the control pins of a synchronous DRAM bus and, on every rising clock, turns the sampled clock-enable history, chip select, row strobe, column strobe, write enable, the A10 qualifier and the bank address into one decoded operation. It keeps a model of which of the four banks hold an open row, follows bursts that close their row automatically, and checks each operation against the bus rules. A broken rule raises a sticky error flag with a code naming the rule. The block also produces the two mask timings of the data mask pin: writes are masked on the clock the mask is sampled, and reads go to high impedance two clocks later.

The block is a passive monitor. It sits beside a memory controller or a memory model and drives nothing onto the bus. A command that breaks a rule is reported and then dropped, so the bank model goes on tracking what a correct device would have done.

The global machine has four states. GS_RUN accepts commands. GS_MRD_WAIT is entered by an accepted mode set, lasts MRD_CYC clocks and then returns to GS_RUN. GS_SELF_REF is entered by self-refresh entry and GS_PDOWN by power-down entry; both go back to GS_RUN on a CKE exit. Each bank has its own machine. BK_IDLE moves to BK_ACTIVE on an activate. BK_ACTIVE moves to BK_AP_BURST on a read or write with auto precharge, and back to BK_IDLE on a precharge. BK_AP_BURST moves to BK_AP_RECOV after BURST_LEN clocks. BK_AP_RECOV moves to BK_IDLE after TRP_CYC clocks.

Top module: `sdc_cmd_checker`

## Requirements
- R1: With CKE high on the previous and the current edge, the lines {cs_n, ras_n, cas_n, we_n} decode as follows. 0000 gives mode set (code 1). 0001 gives refresh (2). 0011 gives activate (5). 0101 gives read (6). 0100 gives write (8). 0110 gives burst stop (10). 0010 gives precharge (11). 0111, or cs_n high, gives NOP (0). The code is shown on cmd_o one clock after the edge that sampled it.
- R2: A10 high turns read into read with auto precharge (7), write into write with auto precharge (9), and precharge into precharge-all (12).
- R3: CKE high then low with the refresh pattern decodes as self-refresh entry (3). CKE high then low with any other pattern decodes as power-down entry (13). CKE low then high decodes as exit (4). CKE low on both edges decodes as 14. CKE is taken as high on the first edge after reset.
- R4: After reset all banks are idle (bank_open_o = 0), err_o is 0, err_code_o is 0, cmd_o is NOP and both mask outputs are 0. An accepted activate sets bank_open_o[ba]. An accepted precharge clears bank_open_o[ba] if that bank is open. An accepted precharge-all clears every open bank.
- R5: A mode set, refresh or self-refresh entry issued while any bank is not idle is a violation with code 1.
- R6: A read or write to a bank that is idle or recovering is a violation with code 2. An activate to a bank that holds an open row is a violation with code 3.
- R7: A read or write with auto precharge keeps its bank busy for BURST_LEN edges, counting the command edge, and then recovering for TRP_CYC edges, after which the bank is idle. A read or write to the bank during the burst is a violation with code 4. An activate to the bank during the burst or the recovery is a violation with code 5.
- R8: Any decoded operation other than NOP on the MRD_CYC edges after an accepted mode set is a violation with code 6.
- R9: A violation sets err_o and err_code_o one clock later. While err_o is set, later violations do not change the code. clr_err clears both, and a violation on the same edge as clr_err is captured as the new code. A command that violates a rule does not change bank or global state.
- R10: wr_mask_o shows the dqm value sampled at the latest edge (write latency 0). rd_hiz_o shows the dqm value sampled two edges earlier (read latency 2).
- R11: During self refresh and power-down, no command can open or close a bank and no violation is raised. Only a CKE exit returns the block to normal decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Auto-precharge / all-bank qualifier |
| ba | input | 2 | Bank address |
| dqm | input | 1 | Data mask pin |
| clr_err | input | 1 | Clears the sticky error |
| cmd_o | output | 4 | Decoded operation code |
| bank_open_o | output | 4 | One bit per bank, set when the bank is not idle |
| err_o | output | 1 | Sticky violation flag |
| err_code_o | output | 3 | Code of the first violation since the last clear |
| wr_mask_o | output | 1 | Write data mask, latency 0 |
| rd_hiz_o | output | 1 | Read output disable, latency 2 |

## Verification
A bank machine stuck in the wrong state shows up on bank_open_o within one clock. It also shows up as a wrong or missing error code the next time that bank is addressed. A countdown that is off by one in the burst or recovery window shows only on the exact edge where an activate or a read lands at the boundary. For that reason the stimulus mixes directed commands placed at those edges with long random traffic, and every output is compared against an independent bench model on every clock. A slip in the global machine changes how the next mode set, refresh or CKE transition is judged, so a wrong state shows up within a few commands as a wrong error code or a wrong cmd_o.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [3:0] {
        CMD_NOP          = 4'd0,
        CMD_MODE_SET     = 4'd1,
        CMD_REFRESH      = 4'd2,
        CMD_SREF_ENTER   = 4'd3,
        CMD_CKE_EXIT     = 4'd4,
        CMD_ACTIVATE     = 4'd5,
        CMD_READ         = 4'd6,
        CMD_READ_AP      = 4'd7,
        CMD_WRITE        = 4'd8,
        CMD_WRITE_AP     = 4'd9,
        CMD_BURST_STOP   = 4'd10,
        CMD_PRE_ONE      = 4'd11,
        CMD_PRE_ALL      = 4'd12,
        CMD_PDOWN_ENTER  = 4'd13,
        CMD_CKE_LOW      = 4'd14
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_BANKS_BUSY = 3'd1,
        ERR_RW_CLOSED  = 3'd2,
        ERR_ACT_OPEN   = 3'd3,
        ERR_AP_RW      = 3'd4,
        ERR_TRP        = 3'd5,
        ERR_MRD_GAP    = 3'd6
    } err_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_ACTIVE,
        BK_AP_BURST,
        BK_AP_RECOV
    } bank_st_e;

    typedef enum logic [1:0] {
        GS_RUN,
        GS_MRD_WAIT,
        GS_SELF_REF,
        GS_PDOWN
    } glob_st_e;

endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
    import sdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    output cmd_e cmd_o
);

    logic cke_q;
    cmd_e pin_cmd;

    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke;
    end

    always_comb begin
        pin_cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b000: pin_cmd = CMD_MODE_SET;
                3'b001: pin_cmd = CMD_REFRESH;
                3'b011: pin_cmd = CMD_ACTIVATE;
                3'b101: pin_cmd = a10 ? CMD_READ_AP  : CMD_READ;
                3'b100: pin_cmd = a10 ? CMD_WRITE_AP : CMD_WRITE;
                3'b110: pin_cmd = CMD_BURST_STOP;
                3'b010: pin_cmd = a10 ? CMD_PRE_ALL  : CMD_PRE_ONE;
                3'b111: pin_cmd = CMD_NOP;
            endcase
        end
    end

    always_comb begin
        unique case ({cke_q, cke})
            2'b00: cmd_o = CMD_CKE_LOW;
            2'b01: cmd_o = CMD_CKE_EXIT;
            2'b10: cmd_o = (pin_cmd == CMD_REFRESH) ? CMD_SREF_ENTER : CMD_PDOWN_ENTER;
            2'b11: cmd_o = pin_cmd;
        endcase
    end

endmodule

// File: rtl/sdc_bank_fsm.sv
module sdc_bank_fsm
    import sdc_pkg::*;
#(
    parameter int BURST_LEN = 4,   // at least 2
    parameter int TRP_CYC   = 2    // at least 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     act_i,
    input  logic     ap_i,
    input  logic     pre_i,
    output bank_st_e st_o
);

    localparam int LIMIT = (BURST_LEN > TRP_CYC) ? BURST_LEN : TRP_CYC;
    localparam int CW    = $clog2(LIMIT + 1);

    bank_st_e st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            BK_IDLE: begin
                if (act_i) st_n = BK_ACTIVE;
            end
            BK_ACTIVE: begin
                if (ap_i) begin
                    st_n  = BK_AP_BURST;
                    cnt_n = CW'(BURST_LEN - 1);
                end else if (pre_i) begin
                    st_n = BK_IDLE;
                end
            end
            BK_AP_BURST: begin
                if (cnt_q == CW'(1)) begin
                    st_n  = BK_AP_RECOV;
                    cnt_n = CW'(TRP_CYC);
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            BK_AP_RECOV: begin
                if (cnt_q == CW'(1)) st_n = BK_IDLE;
                else                 cnt_n = cnt_q - 1'b1;
            end
        endcase
    end

    assign st_o = st_q;

endmodule

// File: rtl/sdc_dqm_pipe.sv
module sdc_dqm_pipe #(
    parameter int WR_LAT = 0,
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dqm,
    output logic wr_mask_o,
    output logic rd_hiz_o
);

    localparam int DEPTH = ((WR_LAT > RD_LAT) ? WR_LAT : RD_LAT) + 1;

    logic [DEPTH-1:0] pipe;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= dqm;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[DEPTH-2:0], dqm};
            end
        end
    endgenerate

    assign wr_mask_o = pipe[WR_LAT];
    assign rd_hiz_o  = pipe[RD_LAT];

endmodule

// File: rtl/sdc_cmd_checker.sv
module sdc_cmd_checker
    import sdc_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int BURST_LEN  = 4,
    parameter int TRP_CYC    = 2,
    parameter int MRD_CYC    = 2,
    parameter int WR_DQM_LAT = 0,
    parameter int RD_DQM_LAT = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cke,
    input  logic                         cs_n,
    input  logic                         ras_n,
    input  logic                         cas_n,
    input  logic                         we_n,
    input  logic                         a10,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic                         dqm,
    input  logic                         clr_err,
    output logic [3:0]                   cmd_o,
    output logic [NUM_BANKS-1:0]         bank_open_o,
    output logic                         err_o,
    output logic [2:0]                   err_code_o,
    output logic                         wr_mask_o,
    output logic                         rd_hiz_o
);

    localparam int BW = $clog2(NUM_BANKS);
    localparam int MW = $clog2(MRD_CYC + 1);

    cmd_e            cmd_d;
    bank_st_e        bk_st [NUM_BANKS];
    logic [NUM_BANKS-1:0] bk_open;
    bank_st_e        tgt_st;
    glob_st_e        gst_q, gst_n;
    logic [MW-1:0]   gcnt_q, gcnt_n;
    err_e            viol_code;
    logic            viol;
    logic            accept;
    cmd_e            cmd_q;
    logic            err_q;
    err_e            code_q;

    sdc_cmd_decode dec_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .a10   (a10),
        .cmd_o (cmd_d)
    );

    generate
        for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
            logic hit;
            assign hit = (ba == BW'(i));
            sdc_bank_fsm #(
                .BURST_LEN (BURST_LEN),
                .TRP_CYC   (TRP_CYC)
            ) bank_i (
                .clk   (clk),
                .rst_n (rst_n),
                .act_i (accept && hit && cmd_d == CMD_ACTIVATE),
                .ap_i  (accept && hit && (cmd_d == CMD_READ_AP || cmd_d == CMD_WRITE_AP)),
                .pre_i (accept && ((hit && cmd_d == CMD_PRE_ONE) || cmd_d == CMD_PRE_ALL)),
                .st_o  (bk_st[i])
            );
            assign bk_open[i] = (bk_st[i] != BK_IDLE);
        end
    endgenerate

    assign tgt_st = bk_st[ba];

    // rule check on the command being sampled
    always_comb begin
        viol_code = ERR_NONE;
        unique case (gst_q)
            GS_MRD_WAIT: begin
                if (cmd_d != CMD_NOP) viol_code = ERR_MRD_GAP;
            end
            GS_RUN: begin
                case (cmd_d)
                    CMD_MODE_SET, CMD_REFRESH, CMD_SREF_ENTER: begin
                        if (|bk_open) viol_code = ERR_BANKS_BUSY;
                    end
                    CMD_ACTIVATE: begin
                        if (tgt_st == BK_ACTIVE)    viol_code = ERR_ACT_OPEN;
                        else if (tgt_st != BK_IDLE) viol_code = ERR_TRP;
                    end
                    CMD_READ, CMD_READ_AP, CMD_WRITE, CMD_WRITE_AP: begin
                        if (tgt_st == BK_AP_BURST)    viol_code = ERR_AP_RW;
                        else if (tgt_st != BK_ACTIVE) viol_code = ERR_RW_CLOSED;
                    end
                    default: ;
                endcase
            end
            GS_SELF_REF, GS_PDOWN: ;
        endcase
    end

    assign viol   = (viol_code != ERR_NONE);
    assign accept = (gst_q == GS_RUN) && !viol;

    // global state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gst_q  <= GS_RUN;
            gcnt_q <= '0;
        end else begin
            gst_q  <= gst_n;
            gcnt_q <= gcnt_n;
        end
    end

    // global next state
    always_comb begin
        gst_n  = gst_q;
        gcnt_n = gcnt_q;
        unique case (gst_q)
            GS_RUN: begin
                if (accept) begin
                    if (cmd_d == CMD_MODE_SET) begin
                        gst_n  = GS_MRD_WAIT;
                        gcnt_n = MW'(MRD_CYC);
                    end else if (cmd_d == CMD_SREF_ENTER) begin
                        gst_n = GS_SELF_REF;
                    end else if (cmd_d == CMD_PDOWN_ENTER) begin
                        gst_n = GS_PDOWN;
                    end
                end
            end
            GS_MRD_WAIT: begin
                if (gcnt_q == MW'(1)) gst_n = GS_RUN;
                else                  gcnt_n = gcnt_q - 1'b1;
            end
            GS_SELF_REF, GS_PDOWN: begin
                if (cmd_d == CMD_CKE_EXIT) gst_n = GS_RUN;
            end
        endcase
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            err_q  <= 1'b0;
            code_q <= ERR_NONE;
        end else begin
            cmd_q <= cmd_d;
            if (viol && (clr_err || !err_q)) begin
                err_q  <= 1'b1;
                code_q <= viol_code;
            end else if (clr_err) begin
                err_q  <= 1'b0;
                code_q <= ERR_NONE;
            end
        end
    end

    sdc_dqm_pipe #(
        .WR_LAT (WR_DQM_LAT),
        .RD_LAT (RD_DQM_LAT)
    ) dqm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dqm       (dqm),
        .wr_mask_o (wr_mask_o),
        .rd_hiz_o  (rd_hiz_o)
    );

    assign cmd_o       = cmd_q;
    assign bank_open_o = bk_open;
    assign err_o       = err_q;
    assign err_code_o  = code_q;

endmodule

// File: rtl/sdc_cmd_checker_sva.sv
module sdc_cmd_checker_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       dqm,
    input logic       clr_err,
    input logic [3:0] cmd_o,
    input logic       err_o,
    input logic [2:0] err_code_o,
    input logic       wr_mask_o,
    input logic       rd_hiz_o
);

    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (!rst_n)          cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R10
    wr_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1) |-> (wr_mask_o == $past(dqm)));

    // R10
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (rd_hiz_o == $past(dqm, 3)));

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clr_err) |=> (err_o && $stable(err_code_o)));

    // R5
    busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_o) && err_code_o == 3'd1) |->
        (cmd_o == 4'd1 || cmd_o == 4'd2 || cmd_o == 4'd3));

    // R7
    trp_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_o) && err_code_o == 3'd5) |-> (cmd_o == 4'd5));

    // R8
    mrd_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_o) && err_code_o == 3'd6) |-> (cmd_o != 4'd0));

    // R3
    cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1 && !cke && !$past(cke)) |=> (cmd_o == 4'd14));

endmodule

bind sdc_cmd_checker sdc_cmd_checker_sva chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .dqm        (dqm),
    .clr_err    (clr_err),
    .cmd_o      (cmd_o),
    .err_o      (err_o),
    .err_code_o (err_code_o),
    .wr_mask_o  (wr_mask_o),
    .rd_hiz_o   (rd_hiz_o)
);

// File: tb/sdc_cmd_checker_tb_top.sv
`timescale 1ns/1ps
module sdc_cmd_checker_tb_top;

    localparam int BL  = 4;
    localparam int TRP = 2;
    localparam int MRD = 2;

    localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_ACT = 3'b011;
    localparam logic [2:0] C_WR  = 3'b100, C_RD  = 3'b101, C_BST = 3'b110, C_NOP = 3'b111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic dqm = 1'b0, clr_err = 1'b0;
    logic [3:0] cmd_o;
    logic [3:0] bank_open_o;
    logic err_o;
    logic [2:0] err_code_o;
    logic wr_mask_o, rd_hiz_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model state
    bit m_ckeq = 1;
    int m_bst [4];
    int m_bcnt [4];
    int m_g = 0;
    int m_gcnt = 0;
    bit m_err = 0;
    int m_code = 0;
    int m_cmd = 0;
    bit m_d0 = 0, m_d1 = 0, m_d2 = 0;

    always #10 clk = ~clk;

    sdc_cmd_checker dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .a10(a10), .ba(ba), .dqm(dqm),
        .clr_err(clr_err), .cmd_o(cmd_o), .bank_open_o(bank_open_o),
        .err_o(err_o), .err_code_o(err_code_o), .wr_mask_o(wr_mask_o),
        .rd_hiz_o(rd_hiz_o)
    );

    function automatic int decode(bit kq, bit k, bit cs, bit r, bit c, bit w, bit ap);
        int p;
        p = 0;
        if (!cs) begin
            case ({r, c, w})
                3'b000: p = 1;
                3'b001: p = 2;
                3'b011: p = 5;
                3'b101: p = ap ? 7 : 6;
                3'b100: p = ap ? 9 : 8;
                3'b110: p = 10;
                3'b010: p = ap ? 12 : 11;
                default: p = 0;
            endcase
        end
        if (!kq && !k) return 14;
        if (!kq && k)  return 4;
        if (kq && !k)  return (p == 2) ? 3 : 13;
        return p;
    endfunction

    function automatic bit any_open();
        for (int i = 0; i < 4; i++) if (m_bst[i] != 0) return 1;
        return 0;
    endfunction

    function automatic logic [3:0] exp_open();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = (m_bst[i] != 0);
        return v;
    endfunction

    task automatic model_step();
        int c, code, tb;
        bit acc;
        c = decode(m_ckeq, cke, cs_n, ras_n, cas_n, we_n, a10);
        m_ckeq = cke;
        tb = m_bst[ba];
        code = 0;
        if (m_g == 1) begin
            if (c != 0) code = 6;
        end else if (m_g == 0) begin
            if (c == 1 || c == 2 || c == 3) begin
                if (any_open()) code = 1;
            end else if (c == 5) begin
                if (tb == 1) code = 3; else if (tb != 0) code = 5;
            end else if (c >= 6 && c <= 9) begin
                if (tb == 2) code = 4; else if (tb != 1) code = 2;
            end
        end
        acc = (m_g == 0) && (code == 0);
        for (int i = 0; i < 4; i++) begin
            if (m_bst[i] == 2) begin
                if (m_bcnt[i] == 1) begin m_bst[i] = 3; m_bcnt[i] = TRP; end
                else m_bcnt[i]--;
            end else if (m_bst[i] == 3) begin
                if (m_bcnt[i] == 1) m_bst[i] = 0;
                else m_bcnt[i]--;
            end
        end
        if (m_g == 0) begin
            if (acc) begin
                case (c)
                    5: m_bst[ba] = 1;
                    7, 9: begin m_bst[ba] = 2; m_bcnt[ba] = BL - 1; end
                    11: if (m_bst[ba] == 1) m_bst[ba] = 0;
                    12: for (int i = 0; i < 4; i++) if (m_bst[i] == 1) m_bst[i] = 0;
                    1: begin m_g = 1; m_gcnt = MRD; end
                    3: m_g = 2;
                    13: m_g = 3;
                    default: ;
                endcase
            end
        end else if (m_g == 1) begin
            if (m_gcnt == 1) m_g = 0; else m_gcnt--;
        end else if (c == 4) begin
            m_g = 0;
        end
        if (code != 0 && (clr_err || !m_err)) begin
            m_err = 1; m_code = code;
        end else if (clr_err) begin
            m_err = 0; m_code = 0;
        end
        m_d2 = m_d1; m_d1 = m_d0; m_d0 = dqm;
        m_cmd = c;
    endtask

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string cmd_req(int c);
        if (c == 7 || c == 9 || c == 12) return "R2";
        if (c == 3 || c == 4 || c == 13 || c == 14) return "R3";
        return "R1";
    endfunction

    function automatic string err_req(int code);
        case (code)
            1: return "R5";
            2, 3: return "R6";
            4, 5: return "R7";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check_all();
        bit ap_busy;
        ap_busy = 0;
        for (int i = 0; i < 4; i++) if (m_bst[i] >= 2) ap_busy = 1;
        check(cmd_req(m_cmd), "cmd_o", int'(cmd_o), m_cmd);
        if (m_g >= 2)     check("R11", "bank_open_o", int'(bank_open_o), int'(exp_open()));
        else if (ap_busy) check("R7", "bank_open_o", int'(bank_open_o), int'(exp_open()));
        else              check("R4", "bank_open_o", int'(bank_open_o), int'(exp_open()));
        if (m_cmd == 14) begin
            check("R11", "err_o", int'(err_o), int'(m_err));
            check("R11", "err_code_o", int'(err_code_o), m_code);
        end else begin
            check(err_req(m_code), "err_o", int'(err_o), int'(m_err));
            check(err_req(m_code), "err_code_o", int'(err_code_o), m_code);
        end
        check("R10", "wr_mask_o", int'(wr_mask_o), int'(m_d0));
        check("R10", "rd_hiz_o", int'(rd_hiz_o), int'(m_d2));
    endtask

    task automatic cyc(bit k, logic [2:0] rcw, bit cs, bit ap, int b, bit dm, bit clr);
        @(negedge clk);
        check_all();
        cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw;
        a10 = ap; ba = 2'(b); dqm = dm; clr_err = clr;
        model_step();
    endtask

    task automatic rnd_cycle();
        int r;
        bit k;
        logic [2:0] rcw;
        bit cs;
        if (m_g >= 2) k = ($urandom % 4 == 0);
        else          k = ($urandom % 25 != 0);
        r = $urandom % 100;
        cs = 0;
        if (r < 20)      rcw = C_NOP;
        else if (r < 45) rcw = C_ACT;
        else if (r < 60) rcw = C_RD;
        else if (r < 72) rcw = C_WR;
        else if (r < 82) rcw = C_PRE;
        else if (r < 87) rcw = C_BST;
        else if (r < 93) rcw = C_REF;
        else if (r < 96) rcw = C_MRS;
        else begin cs = 1; rcw = 3'($urandom % 8); end
        cyc(k, rcw, cs, ($urandom % 3 == 0), $urandom % 4, bit'($urandom % 2),
            ($urandom % 20 == 0));
    endtask

    initial begin
        void'($urandom(32'h5DC0_11A7));
        for (int i = 0; i < 4; i++) begin m_bst[i] = 0; m_bcnt[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state, R4
        check("R4", "reset cmd_o", int'(cmd_o), 0);
        check("R4", "reset bank_open_o", int'(bank_open_o), 0);
        check("R4", "reset err_o", int'(err_o), 0);
        check("R4", "reset err_code_o", int'(err_code_o), 0);
        check("R4", "reset rd_hiz_o", int'(rd_hiz_o), 0);
        rst_n = 1'b1;

        // directed: auto-precharge window (R7), sticky codes (R9)
        cyc(1, C_ACT, 0, 0, 0, 0, 0);
        cyc(1, C_RD,  0, 1, 0, 1, 0);
        cyc(1, C_RD,  0, 0, 0, 0, 0);
        cyc(1, C_NOP, 0, 0, 0, 1, 1);
        cyc(1, C_ACT, 0, 0, 0, 0, 0);
        cyc(1, C_NOP, 0, 0, 0, 0, 1);
        cyc(1, C_NOP, 0, 0, 0, 0, 0);
        // mode set gap (R8)
        cyc(1, C_MRS, 0, 0, 0, 1, 0);
        cyc(1, C_ACT, 0, 0, 1, 0, 0);
        cyc(1, C_NOP, 0, 0, 0, 0, 0);
        cyc(1, C_NOP, 0, 0, 0, 0, 1);
        // open-bank and closed-bank rules (R6), first code kept (R9)
        cyc(1, C_ACT, 0, 0, 1, 0, 0);
        cyc(1, C_ACT, 0, 0, 1, 0, 0);
        cyc(1, C_WR,  0, 0, 2, 0, 0);
        cyc(1, C_REF, 0, 0, 0, 0, 0);
        cyc(1, C_NOP, 0, 0, 0, 0, 1);
        // busy banks (R5), precharge-all (R2), closed write
        cyc(1, C_REF, 0, 0, 0, 0, 0);
        cyc(1, C_PRE, 0, 1, 0, 0, 1);
        cyc(1, C_NOP, 0, 0, 0, 0, 0);
        cyc(1, C_WR,  0, 0, 1, 0, 0);
        cyc(1, C_NOP, 0, 0, 0, 0, 1);
        // self refresh entry and exit (R3, R11)
        cyc(0, C_REF, 0, 0, 0, 0, 0);
        cyc(0, C_ACT, 0, 0, 2, 0, 0);
        cyc(0, C_MRS, 0, 0, 0, 0, 0);
        cyc(1, C_NOP, 1, 0, 0, 0, 0);
        // power-down with an open bank (R3, R11)
        cyc(1, C_ACT, 0, 0, 3, 0, 0);
        cyc(0, C_NOP, 0, 0, 0, 1, 0);
        cyc(0, C_PRE, 0, 1, 0, 1, 0);
        cyc(1, C_NOP, 0, 0, 0, 0, 0);
        cyc(1, C_WR,  0, 1, 3, 1, 0);
        cyc(1, C_BST, 0, 0, 0, 0, 0);
        cyc(1, C_RD,  0, 0, 3, 0, 0);
        for (int i = 0; i < 6; i++) cyc(1, C_NOP, 1, 0, 0, 0, 0);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) rnd_cycle();
        @(negedge clk);
        check_all();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule